// File: doc/BRIEF.md
# Cycle-Stealing DMA Request Arbiter

This block is the request and arbitration front end of a four-channel DMA controller. The controller shares the CPU bus by cycle stealing. Each channel watches two hardware request lines, a primary and a secondary, and one software request. A per-channel select bit decides which of the two hardware lines is active. A channel competes for the bus only while it is armed, which means it has been loaded with a nonzero word count.

When one or more channels are pending, the block latches the highest-priority one and raises a bus request. It waits for the grant. It then runs one read cycle at the channel's source address and one write cycle at its destination address, carrying the data it read. After that it releases the bus for at least one cycle, so the CPU gets the bus back between words. Each completed word pulses an acknowledge to the serviced channel. The word also steps that channel's addresses, if they are set to increment, and decrements its word counter. When the counter runs out, the channel disarms and raises its done flag.

Configuration is loaded one channel at a time through a shared set of configuration inputs and a per-channel load strobe. Both memory-to-I/O and memory-to-memory moves are covered, because each channel has its own increment choices for the source and destination addresses.

Top module: `dma_steal_arb`

## Requirements
- R1: An armed channel is pending when its software request bit is set, or when its selected hardware line is high. A select value of 0 picks the primary line and 1 picks the secondary line. The unselected line has no effect.
- R2: Among pending channels, the one with the lowest index wins (channel 0 highest). The choice is made again before every word.
- R3: In the idle state, bus_req rises on the clock edge after a pending request first appears.
- R4: bus_req stays high with no bus cycle until bus_gnt is seen. After the grant comes a read cycle (bus_cyc=1, bus_we=0, bus_addr = source address). The next cycle is a write cycle (bus_cyc=1, bus_we=1, bus_addr = destination address, bus_wdata = the bus_rdata sampled in the read cycle).
- R5: In the cycle after every write cycle, bus_req is low.
- R6: chan_ack is one-hot. It is high only during the write cycle, on the bit of the channel being serviced.
- R7: After each word, the source address and the destination address each advance by one, but only if the increment bit loaded for that address is 1. Otherwise the address stays the same.
- R8: A channel loaded with count N performs exactly N words. It then clears chan_active, sets chan_done and ignores further requests. Loading a count of 0 leaves the channel inactive with chan_done set.
- R9: A pulse on sw_req_set of an armed channel causes exactly one word. The software bit clears itself when that word completes.
- R10: A channel that has never been loaded since reset ignores its hardware and software requests.
- R11: After reset, bus_req, bus_cyc, chan_ack, chan_active and chan_done are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | NCH | Per-channel load strobe; takes the cfg_* values and arms the channel |
| cfg_sel | input | 1 | Source select to load: 0 primary, 1 secondary |
| cfg_src_inc | input | 1 | Source address increments per word when 1 |
| cfg_dst_inc | input | 1 | Destination address increments per word when 1 |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_count | input | CW | Number of words to move |
| prim_req | input | NCH | Primary hardware request per channel |
| sec_req | input | NCH | Secondary hardware request per channel |
| sw_req_set | input | NCH | Software request set pulse per channel |
| bus_req | output | 1 | Bus request to the CPU |
| bus_gnt | input | 1 | Bus grant from the CPU |
| bus_cyc | output | 1 | DMA bus cycle in progress |
| bus_we | output | 1 | 1 for the write cycle, 0 for the read cycle |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid during the read cycle |
| chan_ack | output | NCH | One-cycle acknowledge of a completed word |
| chan_active | output | NCH | Channel armed |
| chan_done | output | NCH | Channel word count exhausted |

## Verification
The bench uses vectors with mixed select settings. A design that decoded the select bit backwards, or that ORed both hardware lines together, would service a channel whose only raised line is the unselected one.

Two cases test whether the winner is chosen again before every word:
- A lower-index request is raised while a higher-index channel is mid-word. A design that locked onto one channel would keep serving the old channel.
- The bus is released between words. A design that held the bus would keep bus_req high with no gap.

Several cases probe the counter and the software bit:
- A count of two. An off-by-one counter would move one word or three.
- A count of zero. A sloppy design might arm the channel with no words to move.
- A single software pulse. A bit that never cleared would repeat the transfer forever.

Holding the grant low shows whether the block would start a bus cycle without one.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

  // Word sequencer phases: wait for work, request bus, read, write.
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_RD   = 2'd2,
    SEQ_WR   = 2'd3
  } seq_state_t;

endpackage

// File: rtl/dma_chan_ctx.sv
module dma_chan_ctx #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          cfg_sel,
  input  logic          cfg_src_inc,
  input  logic          cfg_dst_inc,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic          prim_req,
  input  logic          sec_req,
  input  logic          sw_set,
  input  logic          word_done,
  output logic          pending,
  output logic          active,
  output logic          done,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr
);

  logic          act_q, act_d;
  logic          done_q, done_d;
  logic          sel_q, sel_d;
  logic          sinc_q, sinc_d;
  logic          dinc_q, dinc_d;
  logic          sw_q, sw_d;
  logic [AW-1:0] src_q, src_d;
  logic [AW-1:0] dst_q, dst_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd_en;

  assign upd_en = load | word_done | sw_set;

  always_comb begin
    act_d  = act_q;
    done_d = done_q;
    sel_d  = sel_q;
    sinc_d = sinc_q;
    dinc_d = dinc_q;
    sw_d   = sw_q;
    src_d  = src_q;
    dst_d  = dst_q;
    cnt_d  = cnt_q;
    if (load) begin
      sel_d  = cfg_sel;
      sinc_d = cfg_src_inc;
      dinc_d = cfg_dst_inc;
      src_d  = cfg_src;
      dst_d  = cfg_dst;
      cnt_d  = cfg_count;
      sw_d   = 1'b0;
      if (cfg_count == '0) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        act_d  = 1'b1;
        done_d = 1'b0;
      end
    end else begin
      if (word_done && act_q) begin
        if (sinc_q) src_d = src_q + AW'(1);
        if (dinc_q) dst_d = dst_q + AW'(1);
        sw_d = 1'b0;
        if (cnt_q == CW'(1)) begin
          cnt_d  = '0;
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      if (sw_set && act_d) sw_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
      sel_q  <= 1'b0;
      sinc_q <= 1'b0;
      dinc_q <= 1'b0;
      sw_q   <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      act_q  <= act_d;
      done_q <= done_d;
      sel_q  <= sel_d;
      sinc_q <= sinc_d;
      dinc_q <= dinc_d;
      sw_q   <= sw_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pending  = act_q & ((sel_q ? sec_req : prim_req) | sw_q);
  assign active   = act_q;
  assign done     = done_q;
  assign src_addr = src_q;
  assign dst_addr = dst_q;

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] idx
);

  // Lowest index wins: scan from the top so lower indices overwrite.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end

  assign any = |pend;

endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
  import dma_steal_pkg::*;
#(
  parameter int IW = 2,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_pend,
  input  logic [IW-1:0] win_idx,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic          bus_cyc,
  output logic          bus_we,
  output logic          word_done,
  output logic [IW-1:0] cur_ch,
  output logic [DW-1:0] hold_data
);

  seq_state_t    state_q, state_d;
  logic [IW-1:0] ch_q;
  logic [DW-1:0] dat_q;
  logic          ch_en;
  logic          dat_en;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_IDLE: if (any_pend) state_d = SEQ_REQ;
      SEQ_REQ:  if (bus_gnt)  state_d = SEQ_RD;
      SEQ_RD:   state_d = SEQ_WR;
      SEQ_WR:   state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  assign ch_en  = (state_q == SEQ_IDLE) && any_pend;
  assign dat_en = (state_q == SEQ_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ch_q <= '0;
    else if (ch_en) ch_q <= win_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= '0;
    else if (dat_en) dat_q <= bus_rdata;
  end

  assign bus_req   = (state_q != SEQ_IDLE);
  assign bus_cyc   = (state_q == SEQ_RD) || (state_q == SEQ_WR);
  assign bus_we    = (state_q == SEQ_WR);
  assign word_done = (state_q == SEQ_WR);
  assign cur_ch    = ch_q;
  assign hold_data = dat_q;

endmodule

// File: rtl/dma_steal_arb.sv
module dma_steal_arb #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cfg_load,
  input  logic           cfg_sel,
  input  logic           cfg_src_inc,
  input  logic           cfg_dst_inc,
  input  logic [AW-1:0]  cfg_src,
  input  logic [AW-1:0]  cfg_dst,
  input  logic [CW-1:0]  cfg_count,
  input  logic [NCH-1:0] prim_req,
  input  logic [NCH-1:0] sec_req,
  input  logic [NCH-1:0] sw_req_set,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           bus_cyc,
  output logic           bus_we,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] chan_ack,
  output logic [NCH-1:0] chan_active,
  output logic [NCH-1:0] chan_done
);

  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] pend;
  logic [NCH-1:0] ch_word_done;
  logic [AW-1:0]  src_a [NCH];
  logic [AW-1:0]  dst_a [NCH];
  logic           any_pend;
  logic [IW-1:0]  win_idx;
  logic [IW-1:0]  cur_ch;
  logic           word_done;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign ch_word_done[i] = word_done && (cur_ch == IW'(i));

    dma_chan_ctx #(
      .AW(AW),
      .CW(CW)
    ) i_ctx (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (cfg_load[i]),
      .cfg_sel    (cfg_sel),
      .cfg_src_inc(cfg_src_inc),
      .cfg_dst_inc(cfg_dst_inc),
      .cfg_src    (cfg_src),
      .cfg_dst    (cfg_dst),
      .cfg_count  (cfg_count),
      .prim_req   (prim_req[i]),
      .sec_req    (sec_req[i]),
      .sw_set     (sw_req_set[i]),
      .word_done  (ch_word_done[i]),
      .pending    (pend[i]),
      .active     (chan_active[i]),
      .done       (chan_done[i]),
      .src_addr   (src_a[i]),
      .dst_addr   (dst_a[i])
    );
  end

  dma_prio_pick #(
    .N (NCH),
    .IW(IW)
  ) i_pick (
    .pend(pend),
    .any (any_pend),
    .idx (win_idx)
  );

  dma_bus_seq #(
    .IW(IW),
    .DW(DW)
  ) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_pend (any_pend),
    .win_idx  (win_idx),
    .bus_gnt  (bus_gnt),
    .bus_rdata(bus_rdata),
    .bus_req  (bus_req),
    .bus_cyc  (bus_cyc),
    .bus_we   (bus_we),
    .word_done(word_done),
    .cur_ch   (cur_ch),
    .hold_data(bus_wdata)
  );

  always_comb begin
    bus_addr = '0;
    if (bus_cyc) bus_addr = bus_we ? dst_a[cur_ch] : src_a[cur_ch];
  end

  assign chan_ack = ch_word_done;

endmodule

// File: rtl/dma_steal_chk.sv
module dma_steal_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic           bus_cyc,
  input logic           bus_we,
  input logic [NCH-1:0] chan_ack,
  input logic [NCH-1:0] chan_active,
  input logic [NCH-1:0] chan_done
);

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_cyc && !bus_gnt) |=> (bus_req && !bus_cyc));

  assert_read_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_we) |-> $past(bus_req && bus_gnt && !bus_cyc));

  assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_we) |-> $past(bus_cyc && !bus_we));

  assert_gap_after_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_we) |=> !bus_req);

  assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_ack));

  assert_ack_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_ack) |-> (bus_cyc && bus_we && bus_req));

  assert_done_excl_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_done & chan_active) == '0);

endmodule

bind dma_steal_arb dma_steal_chk #(.NCH(NCH)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .bus_cyc    (bus_cyc),
  .bus_we     (bus_we),
  .chan_ack   (chan_ack),
  .chan_active(chan_active),
  .chan_done  (chan_done)
);

// File: tb/test_dma_steal_arb.sv
`timescale 1ns/1ps
module test_dma_steal_arb;

  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int DW  = 16;
  localparam int CW  = 8;
  localparam logic [15:0] RMASK = 16'h5A5A;

  // Vector: [19:16] sel, [15:12] prim, [11:8] sec, [7:4] sw, [2:0] expected winner (4 = none)
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {4'b0000, 4'b0001, 4'b0000, 4'b0000, 4'd0},
    {4'b0000, 4'b1000, 4'b0000, 4'b0000, 4'd3},
    {4'b0000, 4'b1010, 4'b0000, 4'b0000, 4'd1},
    {4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'd4},
    {4'b1111, 4'b0000, 4'b0100, 4'b0000, 4'd2},
    {4'b0101, 4'b0010, 4'b0001, 4'b0000, 4'd0},
    {4'b0101, 4'b0001, 4'b1000, 4'b0000, 4'd4},
    {4'b0000, 4'b0000, 4'b0000, 4'b0100, 4'd2},
    {4'b0000, 4'b0100, 4'b0000, 4'b1000, 4'd2},
    {4'b0000, 4'b0000, 4'b0010, 4'b0001, 4'd0},
    {4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'd4},
    {4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'd0}
  };

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] cfg_load;
  logic           cfg_sel, cfg_src_inc, cfg_dst_inc;
  logic [AW-1:0]  cfg_src, cfg_dst;
  logic [CW-1:0]  cfg_count;
  logic [NCH-1:0] prim_req, sec_req, sw_req_set;
  logic           bus_req, bus_gnt, bus_cyc, bus_we;
  logic [AW-1:0]  bus_addr;
  logic [DW-1:0]  bus_wdata, bus_rdata;
  logic [NCH-1:0] chan_ack, chan_active, chan_done;

  int n_chk;
  int n_fail;
  bit finished;
  logic [AW-1:0] wa [4];
  logic [DW-1:0] wd [4];

  dma_steal_arb #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) i_dma_steal_arb (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_sel(cfg_sel),
    .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_count(cfg_count), .prim_req(prim_req),
    .sec_req(sec_req), .sw_req_set(sw_req_set), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_cyc(bus_cyc), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chan_ack(chan_ack), .chan_active(chan_active), .chan_done(chan_done)
  );

  // Memory model: read data is a fixed function of the address.
  assign bus_rdata = bus_addr ^ RMASK;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [AW-1:0] src_base(int c);
    return AW'(16'h0200 + c * 16'h0100);
  endfunction

  function automatic logic [AW-1:0] dst_base(int c);
    return AW'(16'h1000 * (c + 1));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_load = '0; cfg_sel = 1'b0; cfg_src_inc = 1'b0; cfg_dst_inc = 1'b0;
    cfg_src = '0; cfg_dst = '0; cfg_count = '0;
    prim_req = '0; sec_req = '0; sw_req_set = '0;
    bus_gnt = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_ch(input int c, input logic [AW-1:0] s, input logic [AW-1:0] d,
                         input int cnt, input bit sel, input bit si, input bit di);
    cfg_load = '0;
    cfg_load[c] = 1'b1;
    cfg_src = s; cfg_dst = d; cfg_count = CW'(cnt);
    cfg_sel = sel; cfg_src_inc = si; cfg_dst_inc = di;
    @(negedge clk);
    cfg_load = '0;
  endtask

  task automatic pulse_sw(input logic [NCH-1:0] m);
    sw_req_set = m;
    @(negedge clk);
    sw_req_set = '0;
  endtask

  task automatic wait_write(input int n, output bit found,
                            output logic [AW-1:0] a, output logic [DW-1:0] d);
    found = 1'b0; a = '0; d = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (bus_cyc && bus_we) begin
        found = 1'b1; a = bus_addr; d = bus_wdata;
        break;
      end
    end
  endtask

  task automatic count_writes(input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (bus_cyc && bus_we) begin
        if (cnt < 4) begin
          wa[cnt] = bus_addr;
          wd[cnt] = bus_wdata;
        end
        cnt++;
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit            found;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int            k;
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; bus_gnt = 1'b1;

    // R11: reset state
    do_reset();
    chk(bus_req == 1'b0 && bus_cyc == 1'b0, "R11 bus idle after reset", {bus_req, bus_cyc}, 0);
    chk(chan_ack == '0 && chan_active == '0 && chan_done == '0, "R11 channel flags after reset",
        {chan_ack, chan_active, chan_done}, 0);

    // R1/R2/R9: vector table of source select, priority and software requests
    for (int v = 0; v < NV; v++) begin
      do_reset();
      for (int c = 0; c < NCH; c++)
        load_ch(c, src_base(c), dst_base(c), 8, VEC[v][16 + c], 1'b1, 1'b1);
      prim_req = VEC[v][15:12];
      sec_req  = VEC[v][11:8];
      pulse_sw(VEC[v][7:4]);
      wait_write(10, found, a, d);
      if (VEC[v][2:0] == 3'd4) begin
        chk(!found, "R1 no winner expected", int'(a), 0);
      end else begin
        chk(found && a == dst_base(int'(VEC[v][2:0])), "R2 winner destination",
            int'(a), int'(dst_base(int'(VEC[v][2:0]))));
        chk(d == (src_base(int'(VEC[v][2:0])) ^ RMASK), "R4 moved data",
            int'(d), int'(src_base(int'(VEC[v][2:0])) ^ RMASK));
      end
      prim_req = '0; sec_req = '0;
    end

    // R3/R4/R6/R5: exact cycle sequence of one word
    do_reset();
    load_ch(2, 16'h0A00, 16'h0B00, 4, 1'b0, 1'b1, 1'b1);
    prim_req = 4'b0100;
    chk(bus_req == 1'b0, "R3 request low before edge", bus_req, 0);
    @(negedge clk);
    chk(bus_req == 1'b1 && bus_cyc == 1'b0, "R3 request one cycle after pending", {bus_req, bus_cyc}, 2);
    @(negedge clk);
    chk(bus_cyc && !bus_we && bus_addr == 16'h0A00, "R4 read cycle at source",
        int'(bus_addr), 16'h0A00);
    @(negedge clk);
    chk(bus_cyc && bus_we && bus_addr == 16'h0B00 && bus_wdata == (16'h0A00 ^ RMASK),
        "R4 write cycle at destination", int'(bus_wdata), int'(16'h0A00 ^ RMASK));
    chk(chan_ack == 4'b0100, "R6 ack on serviced channel in write cycle", chan_ack, 4'b0100);
    @(negedge clk);
    chk(bus_req == 1'b0 && chan_ack == '0, "R5 request dropped after word", {bus_req, chan_ack}, 0);
    prim_req = '0;

    // R4: request held without a bus cycle until grant
    do_reset();
    bus_gnt = 1'b0;
    load_ch(1, 16'h0300, 16'h3000, 4, 1'b0, 1'b1, 1'b1);
    prim_req = 4'b0010;
    k = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (bus_cyc) k++;
    end
    chk(bus_req == 1'b1 && k == 0, "R4 held request with no grant", k, 0);
    bus_gnt = 1'b1;
    wait_write(6, found, a, d);
    chk(found && a == 16'h3000, "R4 transfer after grant", int'(a), 16'h3000);
    prim_req = '0;

    // R2/R5: winner re-chosen before each word
    do_reset();
    load_ch(3, src_base(3), dst_base(3), 4, 1'b0, 1'b1, 1'b1);
    load_ch(0, src_base(0), dst_base(0), 4, 1'b0, 1'b1, 1'b1);
    prim_req = 4'b1000;
    wait_write(10, found, a, d);
    chk(found && a == dst_base(3), "R2 first word on channel 3", int'(a), int'(dst_base(3)));
    prim_req = 4'b1001;
    wait_write(10, found, a, d);
    chk(found && a == dst_base(0), "R5 next word moves to channel 0", int'(a), int'(dst_base(0)));
    prim_req = '0;

    // R8/R7: count of two, source increments, destination fixed
    do_reset();
    load_ch(0, 16'h0300, 16'h4000, 2, 1'b0, 1'b1, 1'b0);
    prim_req = 4'b0001;
    count_writes(30, k);
    chk(k == 2, "R8 words for count 2", k, 2);
    chk(wa[0] == 16'h4000 && wa[1] == 16'h4000, "R7 fixed destination", int'(wa[1]), 16'h4000);
    chk(wd[0] == (16'h0300 ^ RMASK) && wd[1] == (16'h0301 ^ RMASK), "R7 incrementing source",
        int'(wd[1]), int'(16'h0301 ^ RMASK));
    chk(chan_done[0] && !chan_active[0] && !bus_req, "R8 channel finished",
        {chan_done[0], chan_active[0], bus_req}, 4);
    prim_req = '0;

    // R8: count of zero
    do_reset();
    load_ch(1, 16'h0300, 16'h4000, 0, 1'b0, 1'b1, 1'b1);
    chk(chan_done[1] && !chan_active[1], "R8 zero count done at load",
        {chan_done[1], chan_active[1]}, 2);
    prim_req = 4'b0010;
    count_writes(12, k);
    chk(k == 0, "R8 zero count moves nothing", k, 0);
    prim_req = '0;

    // R9: single software pulse gives one word
    do_reset();
    load_ch(2, 16'h0500, 16'h5000, 5, 1'b0, 1'b1, 1'b1);
    pulse_sw(4'b0100);
    count_writes(30, k);
    chk(k == 1, "R9 one word per software pulse", k, 1);
    chk(chan_active[2] && !chan_done[2], "R9 channel stays armed", {chan_active[2], chan_done[2]}, 2);

    // R10: unloaded channels ignore requests
    do_reset();
    prim_req = 4'b1111; sec_req = 4'b1111;
    pulse_sw(4'b1111);
    count_writes(12, k);
    chk(k == 0 && !bus_req, "R10 unloaded channels ignored", k, 0);
    prim_req = '0; sec_req = '0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule